// File: doc/BRIEF.md
# Half-Bridge Overcurrent Protection Controller

This block sits between the per-phase PWM commands and the gate-enable pair of four half-bridges. Each bridge has its own high-side and low-side overcurrent detector inputs. The block decides, clock by clock, whether each bridge drives high, drives low or floats. Each bridge output is a pair of enables. High-side enable alone means drive-high. Low-side enable alone means drive-low. Both enables clear means high-impedance.

A single mode input selects the overcurrent policy. In limiting mode a trip only shapes the current PWM period, and recovery is automatic. A separate short detector still latches the bridge off when an overcurrent shows up in too many consecutive PWM periods. In shutdown mode any trip latches the bridge off at once. Latched bridges are released by an active-low reset for their pair: bridges 0 and 1 form the first pair, and bridges 2 and 3 form the second. An active-low fault flag reports any latched bridge.

A PWM period starts on a rising edge of the synchronized PWM input of that bridge. The synchronizer adds two clocks of latency from a PWM input to the enables.

Top module: `hb_ocp_ctrl`

## Requirements
- R1: While `rst_ni` is low, or the pair reset of a bridge is low, that bridge is high-impedance (both enables 0). `fault_no` is 1 while `rst_ni` is low.
- R2: With no fault, a bridge whose PWM input is 1 has hs=1, ls=0. With PWM 0 it has hs=0, ls=1. The enables follow the PWM input two clocks later, and hs and ls are never both 1.
- R3: In limiting mode (`mode_latch_i`=0), a low-side overcurrent turns both enables of that bridge off from the next clock while it persists.
- R4: In limiting mode, a high-side overcurrent alone gives hs=0, ls=1 from the next clock while it persists.
- R5: In limiting mode, when the trip ends before the PWM input of the bridge has changed, the bridge is high-impedance. Normal drive resumes only once that PWM input toggles.
- R6: In shutdown mode (`mode_latch_i`=1), any overcurrent on a bridge whose pair reset is high latches that bridge high-impedance from the next clock. The latch holds through PWM toggles and removal of the overcurrent.
- R7: A latched bridge is released only by a low pulse on its pair reset taken while neither of its overcurrent inputs is set. A reset taken with an overcurrent present leaves the bridge latched.
- R8: Bridges act independently. `pair_rst_ni[0]` serves bridges 0 and 1, and `pair_rst_ni[1]` serves bridges 2 and 3.
- R9: In limiting mode, an overcurrent seen in each of SHORT_CYCLES (default 4) consecutive PWM periods latches the bridge. A PWM period is the interval between rising edges. A period without an overcurrent restarts the count.
- R10: `fault_no` is 0 exactly while at least one bridge is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_latch_i | input | 1 | 1 = latching shutdown, 0 = cycle-by-cycle limiting |
| pwm_i | input | NUM_BR | PWM command per bridge, asynchronous |
| oc_hs_i | input | NUM_BR | High-side overcurrent detector per bridge |
| oc_ls_i | input | NUM_BR | Low-side overcurrent detector per bridge |
| pair_rst_ni | input | NUM_BR/BR_PER_PAIR | Active-low fault reset per bridge pair |
| hs_en_o | output | NUM_BR | High-side enable per bridge |
| ls_en_o | output | NUM_BR | Low-side enable per bridge |
| fault_no | output | 1 | Active-low latched-fault flag |

## Verification
The assertions assume that overcurrent and reset inputs are synchronous to the clock and stable across an edge. Only the PWM inputs pass through the synchronizer. The bench therefore changes every input on the falling clock edge. It holds each PWM level for at least four clocks, so that every toggle and rising edge is seen by the synchronizer. The short-detector sequences keep one overcurrent pulse per PWM period. Each pulse is placed clear of the rising edge, so the period it belongs to is never in doubt.

// File: rtl/hb_ocp_pkg.sv
package hb_ocp_pkg;
  typedef enum logic [2:0] {
    BR_HOLD,
    BR_NORM,
    BR_LIM_HS,
    BR_LIM_LS,
    BR_WAIT,
    BR_LATCH
  } br_state_e;
endpackage

// File: rtl/hb_edge_sync.sv
module hb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic tog_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign tog_o  = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/hb_short_cnt.sv
module hb_short_cnt #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic oc_i,
  input  logic cyc_i,
  output logic trip_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          hit;

  assign hit    = seen_q | oc_i;
  assign trip_o = cyc_i & hit & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (cyc_i) begin
      seen_q <= 1'b0;
      if (!hit) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end else begin
      seen_q <= hit;
    end
  end
endmodule

// File: rtl/hb_bridge_fsm.sv
module hb_bridge_fsm
  import hb_ocp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pair_ok_i,
  input  logic latch_mode_i,
  input  logic oc_hs_i,
  input  logic oc_ls_i,
  input  logic pwm_lvl_i,
  input  logic rise_i,
  input  logic tog_i,
  input  logic trip_i,
  output logic hs_o,
  output logic ls_o,
  output logic latched_o
);
  br_state_e state_q, state_d;
  logic      oc_any;

  assign oc_any = oc_hs_i | oc_ls_i;

  always_comb begin
    state_d = state_q;
    if (!pair_ok_i) begin
      state_d = (state_q == BR_LATCH && oc_any) ? BR_LATCH : BR_HOLD;
    end else if (state_q != BR_LATCH) begin
      if (trip_i)                    state_d = BR_LATCH;
      else if (latch_mode_i && oc_any) state_d = BR_LATCH;
      else if (oc_ls_i)              state_d = BR_LIM_LS;
      else if (oc_hs_i)              state_d = BR_LIM_HS;
      else begin
        unique case (state_q)
          BR_HOLD:              state_d = BR_NORM;
          BR_LIM_HS, BR_LIM_LS: state_d = rise_i ? BR_NORM : BR_WAIT;
          BR_WAIT:              state_d = tog_i ? BR_NORM : BR_WAIT;
          default:              state_d = state_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= BR_HOLD;
    else         state_q <= state_d;
  end

  always_comb begin
    hs_o = 1'b0;
    ls_o = 1'b0;
    unique case (state_q)
      BR_NORM: begin
        hs_o = pwm_lvl_i;
        ls_o = ~pwm_lvl_i;
      end
      BR_LIM_HS: ls_o = 1'b1;
      default: ;
    endcase
  end

  assign latched_o = (state_q == BR_LATCH);
endmodule

// File: rtl/hb_ocp_ctrl.sv
module hb_ocp_ctrl #(
  parameter int NUM_BR       = 4,
  parameter int BR_PER_PAIR  = 2,
  parameter int SHORT_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            mode_latch_i,
  input  logic [NUM_BR-1:0]               pwm_i,
  input  logic [NUM_BR-1:0]               oc_hs_i,
  input  logic [NUM_BR-1:0]               oc_ls_i,
  input  logic [NUM_BR/BR_PER_PAIR-1:0]   pair_rst_ni,
  output logic [NUM_BR-1:0]               hs_en_o,
  output logic [NUM_BR-1:0]               ls_en_o,
  output logic                            fault_no
);
  localparam int NUM_PAIR = NUM_BR / BR_PER_PAIR;

  logic [NUM_BR-1:0] latched;

  for (genvar b = 0; b < NUM_BR; b++) begin : g_br
    localparam int P = b / BR_PER_PAIR;
    logic lvl, rise, tog, trip, cnt_clr;

    hb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pwm_i[b]),
      .lvl_o  (lvl),
      .rise_o (rise),
      .tog_o  (tog)
    );

    // count only in limiting mode; shutdown mode latches on its own
    assign cnt_clr = ~pair_rst_ni[P] | latched[b] | mode_latch_i;

    hb_short_cnt #(.CYCLES(SHORT_CYCLES)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clr),
      .oc_i   (oc_hs_i[b] | oc_ls_i[b]),
      .cyc_i  (rise),
      .trip_o (trip)
    );

    hb_bridge_fsm u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pair_ok_i    (pair_rst_ni[P]),
      .latch_mode_i (mode_latch_i),
      .oc_hs_i      (oc_hs_i[b]),
      .oc_ls_i      (oc_ls_i[b]),
      .pwm_lvl_i    (lvl),
      .rise_i       (rise),
      .tog_i        (tog),
      .trip_i       (trip),
      .hs_o         (hs_en_o[b]),
      .ls_o         (ls_en_o[b]),
      .latched_o    (latched[b])
    );
  end

  if (NUM_PAIR * BR_PER_PAIR != NUM_BR) begin : g_bad_cfg
    initial $error("NUM_BR must be a multiple of BR_PER_PAIR");
  end

  assign fault_no = ~|latched;
endmodule

// File: rtl/hb_ocp_ctrl_chk.sv
module hb_ocp_ctrl_chk #(
  parameter int NUM_BR      = 4,
  parameter int BR_PER_PAIR = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          mode_latch_i,
  input logic [NUM_BR-1:0]             oc_hs_i,
  input logic [NUM_BR-1:0]             oc_ls_i,
  input logic [NUM_BR/BR_PER_PAIR-1:0] pair_rst_ni,
  input logic [NUM_BR-1:0]             hs_en_o,
  input logic [NUM_BR-1:0]             ls_en_o,
  input logic                          fault_no
);
  for (genvar b = 0; b < NUM_BR; b++) begin : g_b
    localparam int P = b / BR_PER_PAIR;

    // R1
    pair_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pair_rst_ni[P] |=> !hs_en_o[b] && !ls_en_o[b]);

    // R2
    no_shoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hs_en_o[b] && ls_en_o[b]));

    // R3
    ls_trip_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oc_ls_i[b] |=> !hs_en_o[b] && !ls_en_o[b]);

    // R4
    hs_trip_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oc_hs_i[b] && !oc_ls_i[b] |=> !hs_en_o[b]);

    // R6
    latch_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_latch_i && (oc_hs_i[b] || oc_ls_i[b]) && pair_rst_ni[P] |=> !fault_no);
  end

  // R7
  fault_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_no) |-> !(&$past(pair_rst_ni)));
endmodule

bind hb_ocp_ctrl hb_ocp_ctrl_chk #(
  .NUM_BR      (NUM_BR),
  .BR_PER_PAIR (BR_PER_PAIR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_latch_i (mode_latch_i),
  .oc_hs_i      (oc_hs_i),
  .oc_ls_i      (oc_ls_i),
  .pair_rst_ni  (pair_rst_ni),
  .hs_en_o      (hs_en_o),
  .ls_en_o      (ls_en_o),
  .fault_no     (fault_no)
);

// File: tb/hb_ocp_ctrl_tb.sv
module hb_ocp_ctrl_tb;
  localparam int NB = 4;
  localparam int NCYC = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_latch = 1'b0;
  logic [NB-1:0] pwm = '0;
  logic [NB-1:0] oc_hs = '0;
  logic [NB-1:0] oc_ls = '0;
  logic [1:0]    pair_rst_n = 2'b11;
  logic [NB-1:0] hs_en, ls_en;
  logic          fault_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_ocp_ctrl #(.NUM_BR(NB), .BR_PER_PAIR(2), .SHORT_CYCLES(NCYC), .SYNC_STAGES(2)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .mode_latch_i (mode_latch),
    .pwm_i        (pwm),
    .oc_hs_i      (oc_hs),
    .oc_ls_i      (oc_ls),
    .pair_rst_ni  (pair_rst_n),
    .hs_en_o      (hs_en),
    .ls_en_o      (ls_en),
    .fault_no     (fault_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_br(input int b, input bit e_hs, input bit e_ls, input string req);
    n_chk++;
    if (hs_en[b] !== e_hs || ls_en[b] !== e_ls) begin
      n_err++;
      $display("FAIL %s bridge %0d: hs/ls=%b%b expected %b%b", req, b, hs_en[b], ls_en[b], e_hs, e_ls);
    end
  endtask

  task automatic chk_norm(input int b, input string req);
    chk_br(b, pwm[b], !pwm[b], req);
  endtask

  task automatic chk_fault(input bit e, input string req);
    n_chk++;
    if (fault_n !== e) begin
      n_err++;
      $display("FAIL %s fault_no=%b expected %b", req, fault_n, e);
    end
  endtask

  // one PWM period on bridge b, optionally with a 1-clock high-side trip before the rise
  task automatic period(input int b, input bit with_oc);
    if (with_oc) begin
      oc_hs[b] = 1'b1;
      tick(1);
      oc_hs[b] = 1'b0;
    end
    tick(3);
    pwm[b] = 1'b1;
    tick(4);
    pwm[b] = 1'b0;
    tick(4);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    for (int b = 0; b < NB; b++) chk_br(b, 1'b0, 1'b0, "R1");
    chk_fault(1'b1, "R1");
    rst_ni = 1'b1;
    tick(4);

    // R2 sweep of all PWM patterns
    for (int p = 0; p < (1 << NB); p++) begin
      pwm = NB'(p);
      tick(4);
      for (int b = 0; b < NB; b++) chk_norm(b, "R2");
    end
    chk_fault(1'b1, "R10");

    // R3 low-side trip, input held high
    pwm = 4'b0101;
    tick(4);
    oc_ls[0] = 1'b1;
    tick(2);
    chk_br(0, 1'b0, 1'b0, "R3");
    for (int b = 1; b < NB; b++) chk_norm(b, "R8");
    tick(3);
    chk_br(0, 1'b0, 1'b0, "R3");
    chk_fault(1'b1, "R10");
    oc_ls[0] = 1'b0;
    tick(3);
    chk_br(0, 1'b0, 1'b0, "R5");
    pwm[0] = 1'b0;
    tick(4);
    chk_br(0, 1'b0, 1'b1, "R5");

    // R4 high-side trip, input high
    pwm[0] = 1'b1;
    tick(4);
    chk_br(0, 1'b1, 1'b0, "R2");
    oc_hs[0] = 1'b1;
    tick(2);
    chk_br(0, 1'b0, 1'b1, "R4");
    chk_norm(2, "R8");
    oc_hs[0] = 1'b0;
    tick(3);
    chk_br(0, 1'b0, 1'b0, "R5");
    pwm[0] = 1'b0;
    tick(4);
    chk_br(0, 1'b0, 1'b1, "R5");

    // R9 consecutive-period short detection on bridge 1
    pwm = '0;
    pair_rst_n[0] = 1'b0;
    tick(3);
    chk_br(1, 1'b0, 1'b0, "R1");
    chk_br(0, 1'b0, 1'b0, "R1");
    chk_norm(2, "R8");
    pair_rst_n[0] = 1'b1;
    tick(3);
    for (int k = 0; k < NCYC - 1; k++) period(1, 1'b1);
    chk_fault(1'b1, "R9");
    period(1, 1'b0);
    for (int k = 0; k < NCYC - 1; k++) period(1, 1'b1);
    chk_fault(1'b1, "R9");
    chk_br(1, 1'b0, 1'b1, "R9");
    period(1, 1'b1);
    chk_fault(1'b0, "R9");
    chk_br(1, 1'b0, 1'b0, "R9");
    chk_norm(0, "R8");
    pair_rst_n[0] = 1'b0;
    tick(3);
    pair_rst_n[0] = 1'b1;
    tick(3);
    chk_fault(1'b1, "R7");
    chk_norm(1, "R7");

    // R6 shutdown mode on bridge 2
    mode_latch = 1'b1;
    pwm = 4'b1100;
    tick(4);
    oc_ls[2] = 1'b1;
    tick(1);
    oc_ls[2] = 1'b0;
    tick(1);
    chk_br(2, 1'b0, 1'b0, "R6");
    chk_fault(1'b0, "R10");
    chk_norm(3, "R8");
    for (int k = 0; k < 3; k++) begin
      pwm[2] = ~pwm[2];
      tick(4);
      chk_br(2, 1'b0, 1'b0, "R6");
    end
    pair_rst_n[0] = 1'b0;
    tick(3);
    pair_rst_n[0] = 1'b1;
    tick(3);
    chk_br(2, 1'b0, 1'b0, "R8");
    chk_fault(1'b0, "R8");

    // R7 reset with overcurrent present keeps latch
    oc_hs[2] = 1'b1;
    tick(1);
    pair_rst_n[1] = 1'b0;
    tick(3);
    chk_br(3, 1'b0, 1'b0, "R1");
    pair_rst_n[1] = 1'b1;
    tick(2);
    chk_fault(1'b0, "R7");
    chk_br(2, 1'b0, 1'b0, "R7");
    oc_hs[2] = 1'b0;
    tick(3);
    chk_fault(1'b0, "R7");
    pair_rst_n[1] = 1'b0;
    tick(3);
    chk_fault(1'b1, "R10");
    chk_br(2, 1'b0, 1'b0, "R1");
    pair_rst_n[1] = 1'b1;
    tick(3);
    chk_norm(2, "R7");
    chk_norm(3, "R7");
    chk_fault(1'b1, "R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule